// File: doc/BRIEF.md
# One-time-programmable byte memory model

This block is a synthesizable behavioural model of a small byte-wide memory that can be written only once per bit. Every bit starts at 1. A write can only turn bits to 0. An erase command, which stands in for ultraviolet exposure, is the only way to bring bits back to 1. The depth is a parameter, so simulation can use a reduced array.

Each clock edge samples the control flags and decodes one operating mode from them. The flags are chip enable (active low), output enable (active low), a program-voltage-present flag and an identification-voltage flag on one address line. The modes are standby, program inhibit, program, output disable, identifier readout and array read. The modelled output is a registered data bus with a companion drive indication. A low drive indication stands for a high-impedance bus, and the bus then reads 0x00.

Two sticky flags report misuse. One flags an attempt to write a 1 over a programmed 0. The other flags an identifier read made while any address line other than line 0 and the identification line is nonzero.

Top module: `otpByteStore`

## Requirements
- R1: While reset is low, and after it is released, dataOe and dataOut are 0, both sticky flags are 0, and every byte of the array reads 0xFF.
- R2: If chipEnN is high at an edge, then after that edge dataOe is 0 and dataOut is 0x00, whatever outEnN, progVolt and idVolt are. No byte is written, even with progVolt high (program inhibit).
- R3: If chipEnN is low, progVolt is low and outEnN is high at an edge, then after that edge dataOe is 0, dataOut is 0x00 and the array is unchanged.
- R4: If chipEnN is low, outEnN is low, progVolt is low and idVolt is low at an edge, then after that edge dataOe is 1 and dataOut holds the byte stored at addr before that edge.
- R5: If chipEnN is low and progVolt is high at an edge, and eraseCmd is low, the byte at addr becomes its old value AND dataIn. After that edge dataOe is 0, and a later read returns the new value.
- R6: If eraseCmd is high at an edge, every byte becomes 0xFF at that edge. The erase overrides any program request in the same cycle and leaves both sticky flags as they were.
- R7: If read conditions hold, idVolt is high, and all address lines other than bit 0 and bit 9 (the identification line) are 0, then after that edge dataOe is 1. dataOut is 0x20 when addr[0] is 0, and 0x3D when addr[0] is 1.
- R8: An identifier read with any other address line set returns dataOut 0xFF with dataOe 1. It sets illegalId, which then stays 1 until reset.
- R9: A program request whose dataIn has a 1 where the stored byte has a 0 sets overwriteErr, which then stays 1 until reset. That bit stays 0 in the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; loads the erased array |
| chipEnN | input | 1 | Chip enable, active low |
| outEnN | input | 1 | Output enable, active low |
| progVolt | input | 1 | Program voltage present |
| idVolt | input | 1 | Identification voltage present on address line 9 |
| addr | input | ADDR_W (10) | Byte address |
| dataIn | input | DATA_W (8) | Data to program |
| eraseCmd | input | 1 | Erase whole array to all ones |
| dataOut | output | DATA_W (8) | Registered output data, 0x00 while not driven |
| dataOe | output | 1 | Output bus driven |
| overwriteErr | output | 1 | Sticky: write tried to set a programmed bit |
| illegalId | output | 1 | Sticky: identifier read with other address lines set |

## Verification
The outputs and both sticky flags are registered, so each one changes just after the edge that sampled its inputs, one cycle after the stimulus is applied. The array itself changes at that same edge, so a program or erase shows up on the read that follows it. The bench drives each vector on a falling edge and returns the controls to standby just after the rising edge. It compares outputs at the next falling edge against a reference model. That model is updated only after the expected values have been computed from the pre-edge contents.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_INHIBIT,
    MODE_PROGRAM,
    MODE_OUTOFF,
    MODE_IDREAD,
    MODE_READ
  } otpMode_t;

  // strobes from the mode decoder to the datapath
  typedef struct packed {
    logic progWr;    // clear bits of the addressed byte
    logic rdArr;     // register array byte onto the bus
    logic rdSig;     // register identifier code onto the bus
    logic sigBad;    // identifier read with stray address lines set
    logic eraseAll;  // return every byte to all ones
  } otpStrobe_t;

endpackage

// File: rtl/otpModeCtrl.sv
module otpModeCtrl
  import otp_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int SIG_LINE = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic              outEnN,
  input  logic              progVolt,
  input  logic              idVolt,
  input  logic              eraseCmd,
  input  logic [ADDR_W-1:0] addr,
  output otpStrobe_t        st
);

  localparam logic [ADDR_W-1:0] ONE_A      = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OTHER_MASK = ~(ONE_A | (ONE_A << SIG_LINE));

  otpMode_t mode;

  always_comb begin
    if (chipEnN)       mode = progVolt ? MODE_INHIBIT : MODE_STANDBY;
    else if (progVolt) mode = MODE_PROGRAM;
    else if (outEnN)   mode = MODE_OUTOFF;
    else if (idVolt)   mode = MODE_IDREAD;
    else               mode = MODE_READ;
  end

  always_comb begin
    st.eraseAll = eraseCmd;
    st.progWr   = (mode == MODE_PROGRAM) && !eraseCmd;
    st.rdArr    = (mode == MODE_READ);
    st.rdSig    = (mode == MODE_IDREAD);
    st.sigBad   = (mode == MODE_IDREAD) && (|(addr & OTHER_MASK));
  end

  // R5: at most one datapath action per cycle
  a_r5_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.progWr, st.rdArr, st.rdSig}));

  // R6: erase never coexists with a write strobe
  a_r6_erase_wins: assert property (@(posedge clk) disable iff (!rstN)
    st.eraseAll |-> !st.progWr);

endmodule

// File: rtl/otpDatapath.sv
module otpDatapath
  import otp_pkg::*;
#(
  parameter int                ADDR_W   = 10,
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] MFR_CODE = 8'h20,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'h3D
) (
  input  logic              clk,
  input  logic              rstN,
  input  otpStrobe_t        st,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              overwriteErr,
  output logic              illegalId
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [DATA_W-1:0] curByte;
  logic              setsOne;

  assign curByte = memArr[addr];
  assign setsOne = |(dataIn & ~curByte);

  // array: bits only ever cleared, except by erase or reset
  always_ff @(posedge clk) begin
    if (!rstN || st.eraseAll) begin
      for (int i = 0; i < DEPTH; i++) memArr[i] <= '1;
    end else if (st.progWr) begin
      memArr[addr] <= curByte & dataIn;
    end
  end

  // registered output bus
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOe  <= 1'b0;
      dataOut <= '0;
    end else begin
      dataOe <= st.rdArr | st.rdSig;
      if (st.rdArr)      dataOut <= curByte;
      else if (st.rdSig) dataOut <= st.sigBad ? '1 : (addr[0] ? DEV_CODE : MFR_CODE);
      else               dataOut <= '0;
    end
  end

  // sticky misuse flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      overwriteErr <= 1'b0;
      illegalId    <= 1'b0;
    end else begin
      if (st.progWr && setsOne)  overwriteErr <= 1'b1;
      if (st.rdSig && st.sigBad) illegalId    <= 1'b1;
    end
  end

  // R5: a write never turns a 0 into a 1
  a_r5_only_clears: assert property (@(posedge clk) disable iff (!rstN)
    st.progWr |=> ((memArr[$past(addr)] & ~$past(curByte)) == '0));

  // R7: clean identifier read yields the code chosen by address bit 0
  a_r7_id_code: assert property (@(posedge clk) disable iff (!rstN)
    ($past(st.rdSig) && !$past(st.sigBad)) |->
      (dataOe && dataOut == ($past(addr[0]) ? DEV_CODE : MFR_CODE)));

  // R8: stray address lines during identifier read give all ones
  a_r8_id_bad: assert property (@(posedge clk) disable iff (!rstN)
    ($past(st.rdSig) && $past(st.sigBad)) |-> (dataOut == '1 && illegalId));

  // R8 / R9: flags are sticky
  a_r8_sticky_id: assert property (@(posedge clk) disable iff (!rstN)
    $past(illegalId) |-> illegalId);
  a_r9_sticky_ow: assert property (@(posedge clk) disable iff (!rstN)
    $past(overwriteErr) |-> overwriteErr);

  // R3: undriven bus reads zero
  a_r3_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> (dataOut == '0));

endmodule

// File: rtl/otpByteStore.sv
module otpByteStore
  import otp_pkg::*;
#(
  parameter int                ADDR_W   = 10,
  parameter int                DATA_W   = 8,
  parameter int                SIG_LINE = 9,
  parameter logic [DATA_W-1:0] MFR_CODE = 8'h20,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'h3D
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic              outEnN,
  input  logic              progVolt,
  input  logic              idVolt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              eraseCmd,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              overwriteErr,
  output logic              illegalId
);

  otpStrobe_t st;

  otpModeCtrl #(
    .ADDR_W  (ADDR_W),
    .SIG_LINE(SIG_LINE)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .chipEnN (chipEnN),
    .outEnN  (outEnN),
    .progVolt(progVolt),
    .idVolt  (idVolt),
    .eraseCmd(eraseCmd),
    .addr    (addr),
    .st      (st)
  );

  otpDatapath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .MFR_CODE(MFR_CODE),
    .DEV_CODE(DEV_CODE)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .addr        (addr),
    .dataIn      (dataIn),
    .dataOut     (dataOut),
    .dataOe      (dataOe),
    .overwriteErr(overwriteErr),
    .illegalId   (illegalId)
  );

  // R2: a deselected chip never drives the bus
  a_r2_standby_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $past(chipEnN) |-> !dataOe);

  // R5: programming cycle leaves the bus undriven
  a_r5_prog_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!chipEnN) && $past(progVolt)) |-> !dataOe);

endmodule

// File: tb/tb_otpByteStore.sv
module tb_otpByteStore;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] OTHER_MASK = ~(ADDR_W'(1) | (ADDR_W'(1) << 9));

  logic              clk = 1'b0;
  logic              rstN;
  logic              chipEnN, outEnN, progVolt, idVolt, eraseCmd;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] dataIn;
  logic [DATA_W-1:0] dataOut;
  logic              dataOe, overwriteErr, illegalId;

  int vectors = 0;
  int miscompares = 0;

  logic [DATA_W-1:0] refMem [DEPTH];
  logic refOw, refIll;

  always #5 clk = ~clk;

  otpByteStore dut (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .outEnN(outEnN),
    .progVolt(progVolt), .idVolt(idVolt), .addr(addr), .dataIn(dataIn),
    .eraseCmd(eraseCmd), .dataOut(dataOut), .dataOe(dataOe),
    .overwriteErr(overwriteErr), .illegalId(illegalId)
  );

  task automatic goIdle();
    chipEnN = 1'b1; outEnN = 1'b1; progVolt = 1'b0; idVolt = 1'b0;
    eraseCmd = 1'b0; addr = '0; dataIn = '0;
  endtask

  task automatic checkOut(string tag, logic eOe, logic [7:0] eOut);
    vectors++;
    if (dataOe !== eOe || dataOut !== eOut || overwriteErr !== refOw || illegalId !== refIll) begin
      miscompares++;
      $display("FAIL %s: oe/out/ow/ill actual %b/%h/%b/%b expected %b/%h/%b/%b",
               tag, dataOe, dataOut, overwriteErr, illegalId, eOe, eOut, refOw, refIll);
    end
  endtask

  // drive one vector, predict from pre-edge model, then check
  task automatic applyVec(string tag, logic ce, logic oe, logic pv, logic idv,
                          logic [ADDR_W-1:0] a, logic [7:0] d, logic er);
    logic       eOe;
    logic [7:0] eOut;
    @(negedge clk);
    chipEnN = ce; outEnN = oe; progVolt = pv; idVolt = idv;
    addr = a; dataIn = d; eraseCmd = er;
    eOe = 1'b0; eOut = 8'h00;
    if (ce) begin
      eOe = 1'b0;
    end else if (pv) begin
      if (!er) begin
        if ((d & ~refMem[a]) != 0) refOw = 1'b1;
        refMem[a] = refMem[a] & d;
      end
    end else if (!oe) begin
      eOe = 1'b1;
      if (idv) begin
        if ((a & OTHER_MASK) != 0) begin
          eOut = 8'hFF; refIll = 1'b1;
        end else begin
          eOut = a[0] ? 8'h3D : 8'h20;
        end
      end else begin
        eOut = refMem[a];
      end
    end
    if (er) for (int i = 0; i < DEPTH; i++) refMem[i] = 8'hFF;
    @(posedge clk);
    #1 goIdle();
    @(negedge clk);
    checkOut(tag, eOe, eOut);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; goIdle();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < DEPTH; i++) refMem[i] = 8'hFF;
    refOw = 1'b0; refIll = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : main
    int unsigned seedv;
    seedv = $urandom(32'd4242);
    rstN = 1'b0; goIdle();
    refOw = 1'b0; refIll = 1'b0;
    for (int i = 0; i < DEPTH; i++) refMem[i] = 8'hFF;
    repeat (2) @(negedge clk);
    // R1: outputs in reset
    checkOut("R1 during reset", 1'b0, 8'h00);
    doReset();
    @(negedge clk);
    checkOut("R1 after reset", 1'b0, 8'h00);
    // R1: whole array erased
    for (int i = 0; i < DEPTH; i++)
      applyVec("R1 blank read", 0, 0, 0, 0, ADDR_W'(i), 8'h00, 0);

    // R2: standby with output enable low, and program inhibit
    applyVec("R2 standby", 1, 0, 0, 1, 10'd5, 8'h00, 0);
    applyVec("R2 inhibit", 1, 0, 1, 0, 10'd5, 8'h00, 0);
    applyVec("R2 inhibit no write", 0, 0, 0, 0, 10'd5, 8'h00, 0);
    // R3: output disabled
    applyVec("R3 output off", 0, 1, 0, 0, 10'd5, 8'h00, 0);
    // R5: program and verify
    applyVec("R5 program", 0, 0, 1, 0, 10'd3, 8'hA5, 0);
    applyVec("R5 verify", 0, 0, 0, 0, 10'd3, 8'h00, 0);
    applyVec("R5 program subset", 0, 1, 1, 1, 10'd3, 8'h25, 0);
    applyVec("R5 verify subset", 0, 0, 0, 0, 10'd3, 8'h00, 0);
    // R9: try to set bits back to 1
    applyVec("R9 overwrite", 0, 0, 1, 0, 10'd3, 8'h0F, 0);
    applyVec("R9 bit stays 0", 0, 0, 0, 0, 10'd3, 8'h00, 0);
    // R7: identifier codes
    applyVec("R7 maker code", 0, 0, 0, 1, 10'h200, 8'h00, 0);
    applyVec("R7 device code", 0, 0, 0, 1, 10'h201, 8'h00, 0);
    applyVec("R7 code line9 low", 0, 0, 0, 1, 10'h001, 8'h00, 0);
    // R8: stray address lines
    applyVec("R8 stray lines", 0, 0, 0, 1, 10'h204, 8'h00, 0);
    applyVec("R8 sticky", 0, 0, 0, 1, 10'h200, 8'h00, 0);
    // R6: erase overrides program, flags kept
    applyVec("R6 erase with prog", 0, 1, 1, 0, 10'd3, 8'h00, 1);
    applyVec("R6 erased read", 0, 0, 0, 0, 10'd3, 8'h00, 0);

    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      logic [ADDR_W-1:0] a;
      r = $urandom_range(0, 99);
      a = ADDR_W'($urandom_range(0, 31));
      if (r < 10)      applyVec("R2 rnd standby", 1, 1'($urandom), 1'($urandom), 1'($urandom), a, 8'($urandom), 0);
      else if (r < 16) applyVec("R3 rnd off", 0, 1, 0, 1'($urandom), a, 8'($urandom), 0);
      else if (r < 45) applyVec("R4 rnd read", 0, 0, 0, 0, a, 8'($urandom), 0);
      else if (r < 70) applyVec("R5 rnd program", 0, 1'($urandom), 1, 1'($urandom), a,
                                8'($urandom) | 8'($urandom), 0);
      else if (r < 84) applyVec("R7 rnd id", 0, 0, 0, 1,
                                {1'($urandom), 8'h00, 1'($urandom)}, 8'($urandom), 0);
      else if (r < 88) applyVec("R8 rnd id bad", 0, 0, 0, 1,
                                ADDR_W'($urandom) | 10'h002, 8'($urandom), 0);
      else if (r < 90) applyVec("R6 rnd erase", 1, 1, 0, 0, a, 8'($urandom), 1);
      else             applyVec("R4 rnd wide read", 0, 0, 0, 0, ADDR_W'($urandom), 8'h00, 0);
    end

    // R1: reset clears sticky flags
    doReset();
    @(negedge clk);
    checkOut("R1 flags cleared", 1'b0, 8'h00);
    applyVec("R1 read after reset", 0, 0, 0, 0, 10'd3, 8'h00, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule